// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps a system through a change of clock rate. Software picks a new rate by writing a one-hot code into an 8-bit control register. A change starts only when a legal code turns on a bit that was off before. The block then runs a fixed handshake. It raises a freeze request and waits for the freeze acknowledge. After that it pulls a group of active-low clock-change lines low and turns on a PLL bypass. It then lets go of the lines and the bypass, and finally lifts the freeze. A one-cycle marker shows when the first bus clock edge at the new rate is due.

Every wait in the handshake is counted in cycles of the sequencer clock. That clock runs at half the system rate. Four delay registers, written through the same port as the control register, set the waits. A fixed, parameterised hold sets how long the bypass stays on. While a change is in progress the block reports busy. New trigger writes during that time start nothing, and clearing the control register does not stop the change already running.

Top module: `cfs_seq_top`

## Requirements
- R1: After reset, freeze_n is 1, every chg_n line is 1, pll_bypass is 0, rate_edge is 0 and busy is 0.
- R2: A write with wr_sel = 0 (control) whose low byte is exactly 0x01 (full rate), 0x02 (half rate) or 0x20 (1/32 rate), where that bit was 0 in the control register, makes busy 1 and freeze_n 0 from the write edge onward.
- R3: A control write starts nothing when its low byte is zero, has more than one bit set, sets only a reserved bit (bit 2, 3, 4, 6 or 7), or repeats a code bit that is already set.
- R4: The block holds the freeze request until freeze_ack is sampled 1. All chg_n lines then go low together, ACT+1 edges after the edge that sampled the acknowledge.
- R5: pll_bypass rises ABT+1 edges after the chg_n lines go low.
- R6: pll_bypass stays on for exactly HOLD_CYC edges (default 64). Then the chg_n lines return high and pll_bypass falls, both on the same edge.
- R7: freeze_n returns to 1 PST+1 edges after the chg_n lines are released.
- R8: rate_edge is high for a single cycle, FSL+1 edges after the chg_n lines are released.
- R9: busy stays 1 until both the PST and the FSL waits are over. It falls one edge after the later of the two, and after that a new trigger is accepted.
- R10: While busy is 1, control writes (including a clear to 0 and legal codes) neither abort the change nor start a new one. They still update the control register, and that value decides whether a later write is a rising transition.
- R11: The delay registers are selected by wr_sel: 1 is ACT (8 bits), 2 is ABT (16 bits), 3 is PST (32 bits) and 4 is FSL (32 bits). Each value is taken when its wait begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, half the system rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 ACT, 2 ABT, 3 PST, 4 FSL |
| wr_data | input | DATA_W | Write data; the control register uses bits 7:0 |
| freeze_ack | input | 1 | Freeze acknowledge from the system |
| freeze_n | output | 1 | Active-low freeze request |
| chg_n | output | N_CHG | Active-low clock-change lines |
| pll_bypass | output | 1 | PLL bypass request |
| rate_edge | output | 1 | One-cycle marker: first clock edge at the new rate is due |
| busy | output | 1 | A change sequence is in progress |

## Verification
The bench builds the block with HOLD_CYC = 8 and N_CHG = 3, and leaves the delay widths at their defaults. The short hold keeps each sequence brief, so one run can cover zero delays in every phase, the largest 8-bit ACT value of 255, and PST and FSL set equal, shorter and longer than each other. The effect of the later settle wait on busy then shows in each of those cases. Mid-sequence clears and legal writes, followed by a repeat write of the stored code, expose any abort or any lost control update.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FRZ,
      ST_WACT,
      ST_CHG,
      ST_BYP,
      ST_SETL
   } seq_st_e;

   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_ACT  = 3'd1;
   localparam logic [2:0] SEL_ABT  = 3'd2;
   localparam logic [2:0] SEL_PST  = 3'd3;
   localparam logic [2:0] SEL_FSL  = 3'd4;

   localparam int CTRL_W = 8;

   localparam logic [CTRL_W-1:0] CODE_FULL = 8'h01;
   localparam logic [CTRL_W-1:0] CODE_HALF = 8'h02;
   localparam logic [CTRL_W-1:0] CODE_SLOW = 8'h20;

   function automatic logic code_legal(input logic [CTRL_W-1:0] v);
      return (v == CODE_FULL) || (v == CODE_HALF) || (v == CODE_SLOW);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfs_regs.sv
module cfs_regs
   import cfs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACT_W  = 8,
   parameter int ABT_W  = 16,
   parameter int PST_W  = 32,
   parameter int FSL_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              trig,
   output logic [ACT_W-1:0]  act_q,
   output logic [ABT_W-1:0]  abt_q,
   output logic [PST_W-1:0]  pst_q,
   output logic [FSL_W-1:0]  fsl_q
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [CTRL_W-1:0] new_code;
   logic [CTRL_W-1:0] rise_bits;

   assign new_code  = wr_data[CTRL_W-1:0];
   assign rise_bits = new_code & ~ctrl_q;
   assign trig      = wr_en && (wr_sel == SEL_CTRL) && code_legal(new_code)
                      && (rise_bits != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         act_q  <= '0;
         abt_q  <= '0;
         pst_q  <= '0;
         fsl_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_CTRL: ctrl_q <= new_code;
            SEL_ACT:  act_q  <= wr_data[ACT_W-1:0];
            SEL_ABT:  abt_q  <= wr_data[ABT_W-1:0];
            SEL_PST:  pst_q  <= wr_data[PST_W-1:0];
            SEL_FSL:  fsl_q  <= wr_data[FSL_W-1:0];
            default: ;
         endcase
      end
   end

   // R10
   ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CTRL) |=> (ctrl_q == $past(new_code)));

   // R11
   act_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_ACT) |=> (act_q == $past(wr_data[ACT_W-1:0])));

endmodule

// File: rtl/cfs_dcount.sv
module cfs_dcount #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         run,
   output logic         last
);

   logic [W-1:0] cnt;

   assign last = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= val;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - W'(1);
      end
   end

   // R9
   cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !load) |=> !run);

   // R11
   cnt_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> !run);

endmodule

// File: rtl/cfs_fsm.sv
module cfs_fsm
   import cfs_pkg::*;
#(
   parameter int SEQ_W    = 16,
   parameter int HOLD_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             ack,
   input  logic [SEQ_W-1:0] act_v,
   input  logic [SEQ_W-1:0] abt_v,
   input  logic             seq_run,
   input  logic             seq_last,
   input  logic             pst_run,
   input  logic             pst_last,
   input  logic             fsl_run,
   input  logic             fsl_last,
   output logic             seq_load,
   output logic [SEQ_W-1:0] seq_val,
   output logic             set_load,
   output logic             freeze_on,
   output logic             chg_on,
   output logic             byp_on,
   output logic             busy,
   output logic             rate_edge
);

   seq_st_e st, nxt;

   always_comb begin
      nxt      = st;
      seq_load = 1'b0;
      seq_val  = '0;
      set_load = 1'b0;
      case (st)
         ST_IDLE: if (trig) nxt = ST_FRZ;
         ST_FRZ: if (ack) begin
            nxt      = ST_WACT;
            seq_load = 1'b1;
            seq_val  = act_v;
         end
         ST_WACT: if (seq_last) begin
            nxt      = ST_CHG;
            seq_load = 1'b1;
            seq_val  = abt_v;
         end
         ST_CHG: if (seq_last) begin
            nxt      = ST_BYP;
            seq_load = 1'b1;
            seq_val  = SEQ_W'(HOLD_CYC - 1);
         end
         ST_BYP: if (seq_last) begin
            nxt      = ST_SETL;
            set_load = 1'b1;
         end
         ST_SETL: if (!pst_run && !fsl_run) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         rate_edge <= 1'b0;
      end else begin
         st        <= nxt;
         rate_edge <= (st == ST_SETL) && fsl_last;
      end
   end

   assign busy      = (st != ST_IDLE);
   assign chg_on    = (st == ST_CHG) || (st == ST_BYP);
   assign byp_on    = (st == ST_BYP);
   assign freeze_on = (st == ST_FRZ) || (st == ST_WACT) || chg_on
                      || ((st == ST_SETL) && pst_run);

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trig));

   // R4
   chg_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_on) |-> $past(seq_last));

   // R5
   seq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CHG) |-> seq_run);

   // R7
   pst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pst_last |=> !freeze_on);

   // R8
   rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_edge |=> !rate_edge);

   // R10
   no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st != ST_SETL) |=> busy);

endmodule

// File: rtl/cfs_seq_top.sv
module cfs_seq_top
   import cfs_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ACT_W    = 8,
   parameter int ABT_W    = 16,
   parameter int PST_W    = 32,
   parameter int FSL_W    = 32,
   parameter int HOLD_CYC = 64,
   parameter int N_CHG    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              freeze_ack,
   output logic              freeze_n,
   output logic [N_CHG-1:0]  chg_n,
   output logic              pll_bypass,
   output logic              rate_edge,
   output logic              busy
);

   localparam int HOLD_W = $clog2(HOLD_CYC) + 1;
   localparam int SEQ_W  = max2(max2(ACT_W, ABT_W), HOLD_W);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end
   if (N_CHG < 1) begin : g_bad_lines
      $error("N_CHG must be at least 1");
   end
   if (DATA_W < CTRL_W || DATA_W < max2(max2(ACT_W, ABT_W), max2(PST_W, FSL_W)))
   begin : g_bad_data
      $error("DATA_W narrower than a register");
   end

   logic              trig;
   logic [ACT_W-1:0]  act_q;
   logic [ABT_W-1:0]  abt_q;
   logic [PST_W-1:0]  pst_q;
   logic [FSL_W-1:0]  fsl_q;
   logic              seq_load, set_load;
   logic [SEQ_W-1:0]  seq_val;
   logic              seq_run, seq_last;
   logic              pst_run, pst_last;
   logic              fsl_run, fsl_last;
   logic              freeze_on, chg_on, byp_on;

   cfs_regs #(
      .DATA_W(DATA_W), .ACT_W(ACT_W), .ABT_W(ABT_W), .PST_W(PST_W), .FSL_W(FSL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .trig(trig), .act_q(act_q), .abt_q(abt_q), .pst_q(pst_q), .fsl_q(fsl_q)
   );

   cfs_dcount #(.W(SEQ_W)) u_seq_cnt (
      .clk(clk), .rst_n(rst_n), .load(seq_load), .val(seq_val),
      .run(seq_run), .last(seq_last)
   );

   cfs_dcount #(.W(PST_W)) u_pst_cnt (
      .clk(clk), .rst_n(rst_n), .load(set_load), .val(pst_q),
      .run(pst_run), .last(pst_last)
   );

   cfs_dcount #(.W(FSL_W)) u_fsl_cnt (
      .clk(clk), .rst_n(rst_n), .load(set_load), .val(fsl_q),
      .run(fsl_run), .last(fsl_last)
   );

   cfs_fsm #(.SEQ_W(SEQ_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .trig(trig), .ack(freeze_ack),
      .act_v(SEQ_W'(act_q)), .abt_v(SEQ_W'(abt_q)),
      .seq_run(seq_run), .seq_last(seq_last),
      .pst_run(pst_run), .pst_last(pst_last),
      .fsl_run(fsl_run), .fsl_last(fsl_last),
      .seq_load(seq_load), .seq_val(seq_val), .set_load(set_load),
      .freeze_on(freeze_on), .chg_on(chg_on), .byp_on(byp_on),
      .busy(busy), .rate_edge(rate_edge)
   );

   for (genvar i = 0; i < N_CHG; i++) begin : g_chg
      assign chg_n[i] = ~chg_on;
   end

   assign freeze_n   = ~freeze_on;
   assign pll_bypass = byp_on;

   // R6
   byp_inside_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_bypass |-> (chg_n == '0));

   // R4
   chg_under_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_n != {N_CHG{1'b1}}) |-> !freeze_n);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (freeze_n && !pll_bypass && chg_n == {N_CHG{1'b1}}));

endmodule

// File: tb/sim_cfs_seq_top.sv
module sim_cfs_seq_top;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 8;
   localparam int NCHG       = 3;
   localparam int DW         = 32;

   localparam int K_FRZ_ON  = 0;
   localparam int K_CHG_ON  = 1;
   localparam int K_BYP_ON  = 2;
   localparam int K_REL     = 3;
   localparam int K_FRZ_OFF = 4;
   localparam int K_RATE    = 5;
   localparam int K_IDLE    = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [2:0]      wr_sel = 3'd0;
   logic [DW-1:0]   wr_data = '0;
   logic            ack = 1'b0;
   logic            freeze_n, byp, rate, busy;
   logic [NCHG-1:0] chg_n;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int kind;
      int at;
   } exp_t;

   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfs_seq_top #(.HOLD_CYC(HOLD), .N_CHG(NCHG)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .freeze_ack(ack), .freeze_n(freeze_n), .chg_n(chg_n),
      .pll_bypass(byp), .rate_edge(rate), .busy(busy)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic string tag(input int k);
      case (k)
         K_FRZ_ON:  return "R2 freeze-on";
         K_CHG_ON:  return "R4/R11 change-on";
         K_BYP_ON:  return "R5 bypass-on";
         K_REL:     return "R6 release";
         K_FRZ_OFF: return "R7 freeze-off";
         K_RATE:    return "R8 rate-edge";
         default:   return "R9 idle";
      endcase
   endfunction

   task automatic push(input int k, input int at);
      exp_t e;
      e.kind = k;
      e.at   = at;
      exp_q.push_back(e);
   endtask

   task automatic see(input int k);
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL %s: unexpected event at cycle %0d (expected none)", tag(k), cyc);
      end else begin
         e = exp_q.pop_front();
         if (e.kind != k || e.at != cyc) begin
            errors++;
            $display("FAIL %s: got %s at cycle %0d, expected %s at cycle %0d",
                     tag(e.kind), tag(k), cyc, tag(e.kind), e.at);
         end
      end
   endtask

   // monitor: pops expected events as the outputs change
   logic            pf, pb, pr, pbusy;
   logic [NCHG-1:0] pc;

   always @(negedge clk) begin
      if (mon_on) begin
         if (chg_n != '0 && chg_n != {NCHG{1'b1}}) begin
            errors++;
            $display("FAIL R4: change lines split, got %b expected all equal", chg_n);
         end
         if (pf && !freeze_n) see(K_FRZ_ON);
         if (pc == {NCHG{1'b1}} && chg_n == '0) see(K_CHG_ON);
         if (!pb && byp) see(K_BYP_ON);
         if (pc == '0 && chg_n == {NCHG{1'b1}}) begin
            see(K_REL);
            checks++;
            if (byp) begin
               errors++;
               $display("FAIL R6: bypass at release got 1 expected 0");
            end
         end
         if (!pf && freeze_n) see(K_FRZ_OFF);
         if (!pr && rate) see(K_RATE);
         if (pr) begin
            checks++;
            if (rate) begin
               errors++;
               $display("FAIL R8: rate_edge width got >1 cycle expected 1");
            end
         end
         if (pbusy && !busy) see(K_IDLE);
      end
      pf = freeze_n;
      pb = byp;
      pr = rate;
      pbusy = busy;
      pc = chg_n;
   end

   task automatic wr(input logic [2:0] s, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_sel = s;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_quiet(input string req, input logic [7:0] code);
      wr(3'd0, {24'h0, code});
      repeat (6) @(negedge clk);
      checks++;
      if (busy || !freeze_n) begin
         errors++;
         $display("FAIL %s: code %h started a change, got busy=%0b freeze_n=%0b expected 0/1",
                  req, code, busy, freeze_n);
      end
   endtask

   task automatic run_seq(input logic [7:0] code, input int act, input int abt,
                          input int pst, input int fsl, input int ackw,
                          input bit mid_wr, input logic [7:0] mid_code);
      int ew, ea, ec, eb, er, guard;
      wr(3'd1, DW'(act));
      wr(3'd2, DW'(abt));
      wr(3'd3, DW'(pst));
      wr(3'd4, DW'(fsl));
      @(negedge clk);
      ew = cyc + 1;
      ea = ew + 1 + ackw;
      ec = ea + act + 1;
      eb = ec + abt + 1;
      er = eb + HOLD;
      push(K_FRZ_ON, ew);
      push(K_CHG_ON, ec);
      push(K_BYP_ON, eb);
      push(K_REL, er);
      if (pst <= fsl) begin
         push(K_FRZ_OFF, er + pst + 1);
         push(K_RATE, er + fsl + 1);
      end else begin
         push(K_RATE, er + fsl + 1);
         push(K_FRZ_OFF, er + pst + 1);
      end
      push(K_IDLE, er + ((pst > fsl) ? pst : fsl) + 2);
      wr_en = 1'b1;
      wr_sel = 3'd0;
      wr_data = {24'h0, code};
      @(negedge clk);
      wr_en = 1'b0;
      repeat (ackw) @(negedge clk);
      ack = 1'b1;
      if (mid_wr) begin
         // R10: clear and a legal code while busy
         wr(3'd0, '0);
         wr(3'd0, {24'h0, mid_code});
      end
      guard = 0;
      while (exp_q.size() > 0 && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      checks++;
      if (exp_q.size() > 0) begin
         errors++;
         $display("FAIL R9: sequence incomplete, got %0d events left expected 0", exp_q.size());
         exp_q.delete();
      end
      ack = 1'b0;
      repeat (2) @(negedge clk);
      checks++;
      if (busy || !freeze_n || byp || chg_n != {NCHG{1'b1}}) begin
         errors++;
         $display("FAIL R9: not idle after sequence, got busy=%0b freeze_n=%0b byp=%0b chg_n=%b expected 0/1/0/all ones",
                  busy, freeze_n, byp, chg_n);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (!freeze_n || chg_n != {NCHG{1'b1}} || byp || rate || busy) begin
         errors++;
         $display("FAIL R1: reset state got freeze_n=%0b chg_n=%b byp=%0b rate=%0b busy=%0b expected 1/all ones/0/0/0",
                  freeze_n, chg_n, byp, rate, busy);
      end
      mon_on = 1'b1;

      // R3: illegal control values
      check_quiet("R3", 8'h00);
      check_quiet("R3", 8'h03);
      check_quiet("R3", 8'h21);
      check_quiet("R3", 8'h04);
      check_quiet("R3", 8'h80);
      check_quiet("R3", 8'h10);

      run_seq(8'h01, 2, 3, 4, 6, 5, 1'b0, 8'h00);
      check_quiet("R3", 8'h01);

      run_seq(8'h20, 0, 0, 0, 0, 0, 1'b1, 8'h02);
      // R10: the busy write stored 0x02, so rewriting it is not a rise
      check_quiet("R10", 8'h02);

      run_seq(8'h20, 0, 1, 9, 1, 2, 1'b0, 8'h00);

      wr(3'd0, '0);
      run_seq(8'h02, 255, 0, 0, 3, 1, 1'b1, 8'h20);
      check_quiet("R10", 8'h20);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule